// File: doc/BRIEF.md
# Flit Reassembly Controller

This block sits on the receive side of a network interface. It takes flits from a router's local output channel through a valid/acknowledge handshake and rebuilds the data word each packet carries. A packet opens with a routing flit, which is dropped. A second flit follows with the sender's identity, and the block keeps only the sender's index from it. Then come payload flits, and the packet closes with a trailer flit that also carries data. The data fields of the payload flits and the trailer are joined into one word.

Once a word is complete, the block presents the word and the source index and raises a completion flag. While that flag is high it refuses further flits, which holds the router back, until the consumer strobes that it has taken the word. A flit whose type code does not fit its place in the packet aborts the packet: the block raises a one-cycle error pulse and waits for a new routing flit.

Top module: `flit_unpacker`

## Requirements
- R1: After reset, flit_ack_o is 1, data_ok_o is 0 and err_o is 0.
- R2: A flit is {type[1:0], data[FLIT_DATA_W-1:0]} with the type in the top two bits: 2'b10 opens a packet, 2'b00 is a middle flit, 2'b01 is the trailer and 2'b11 is never valid. A flit is taken only on a rising clock edge where flit_val_i and flit_ack_o are both 1.
- R3: The second flit of a packet, type 2'b00, supplies the source index, which is its low $clog2(NUM_SRC) data bits. That index appears on src_o together with the finished word.
- R4: word_o is made of the data fields of the WORD_W/FLIT_DATA_W - 1 middle flits that follow the source flit and of the trailer. The first of these flits is in the most significant position. Data from the routing flit and the source flit never appear in the word.
- R5: data_ok_o goes to 1 right after the edge that takes the trailer. While data_ok_o is 1, flit_ack_o is 0 and word_o and src_o hold their values.
- R6: consume_i while data_ok_o is 1 makes data_ok_o 0 and flit_ack_o 1 after the next edge. consume_i while data_ok_o is 0 has no effect.
- R7: Each of the following counts as a protocol error: a flit other than 2'b10 when no packet is open; a flit other than 2'b00 as the source flit; a 2'b10 or 2'b11 flit among the payload; a trailer that arrives before all the middle flits; a middle flit where the trailer is due. After the edge that takes the faulty flit, err_o is 1 for one cycle, no word is reported, and the block waits for a new 2'b10 flit.
- R8: A flit offered while data_ok_o is 1 is not taken and leaves the held word unchanged. It is taken once the word has been consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flit_val_i | input | 1 | Router offers a flit |
| flit_i | input | FLIT_DATA_W+2 | Flit type and data |
| flit_ack_o | output | 1 | Block accepts the offered flit |
| word_o | output | WORD_W | Reassembled word |
| src_o | output | $clog2(NUM_SRC) | Source index of the word |
| data_ok_o | output | 1 | Word complete and held |
| consume_i | input | 1 | Consumer takes the held word |
| err_o | output | 1 | One-cycle protocol error pulse |

## Verification
Every result is due right after one clock edge. data_ok_o rises and flit_ack_o falls after the edge that takes the trailer. err_o is high for exactly the one cycle after the edge that takes the faulty flit. flit_ack_o comes back after the edge that samples consume_i. The bench drives its inputs on falling edges and updates a behavioural model on each rising edge. It compares every output with that model on the following falling edge, so each check lands in the cycle where that result has already settled. Directed checks also compare each finished word and source index with values that the bench assembles by hand from the flits it sent.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
   typedef enum logic [1:0] {
      FT_MID  = 2'b00,
      FT_TAIL = 2'b01,
      FT_HEAD = 2'b10,
      FT_BAD  = 2'b11
   } flit_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SRC  = 2'd1,
      ST_BODY = 2'd2,
      ST_HOLD = 2'd3
   } unpk_state_e;
endpackage

// File: rtl/unpk_word_shift.sv
module unpk_word_shift #(
   parameter int FLIT_DATA_W = 16,
   parameter int WORD_W      = 32,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   shift_en,
   input  logic [FLIT_DATA_W-1:0] din,
   output logic [WORD_W-1:0]      word_o
);
   localparam int REST_W = WORD_W - FLIT_DATA_W;

   logic [WORD_W-1:0] acc_q;

   generate
      if (REST_W == 0) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        acc_q <= '0;
            else if (shift_en) acc_q <= din;
         end
      end else if (MSB_FIRST) begin : g_msb_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        acc_q <= '0;
            else if (shift_en) acc_q <= {acc_q[REST_W-1:0], din};
         end
      end else begin : g_lsb_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        acc_q <= '0;
            else if (shift_en) acc_q <= {din, acc_q[WORD_W-1:FLIT_DATA_W]};
         end
      end
   endgenerate

   assign word_o = acc_q;
endmodule

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
   import unpk_pkg::*;
#(
   parameter int FLITS_PER_WORD = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xfer,
   input  flit_kind_e kind,
   input  logic       consume_i,
   output logic       shift_en,
   output logic       src_load,
   output logic       data_ok_o,
   output logic       err_o
);
   localparam int MID_NEED = FLITS_PER_WORD - 1;
   localparam int CNT_W    = $clog2(FLITS_PER_WORD + 1);

   unpk_state_e      state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             err_d;

   always_comb begin
      state_d  = state_q;
      cnt_d    = cnt_q;
      err_d    = 1'b0;
      shift_en = 1'b0;
      src_load = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (xfer) begin
               if (kind == FT_HEAD) state_d = ST_SRC;
               else                 err_d   = 1'b1;
            end
         end
         ST_SRC: begin
            if (xfer) begin
               if (kind == FT_MID) begin
                  state_d  = ST_BODY;
                  src_load = 1'b1;
                  cnt_d    = '0;
               end else begin
                  err_d   = 1'b1;
                  state_d = ST_IDLE;
               end
            end
         end
         ST_BODY: begin
            if (xfer) begin
               if (kind == FT_MID && cnt_q < CNT_W'(MID_NEED)) begin
                  shift_en = 1'b1;
                  cnt_d    = cnt_q + 1'b1;
               end else if (kind == FT_TAIL && cnt_q == CNT_W'(MID_NEED)) begin
                  shift_en = 1'b1;
                  state_d  = ST_HOLD;
               end else begin
                  err_d   = 1'b1;
                  state_d = ST_IDLE;
               end
            end
         end
         ST_HOLD: begin
            if (consume_i) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         err_o   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         err_o   <= err_d;
      end
   end

   assign data_ok_o = (state_q == ST_HOLD);

   assert_err_needs_flit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(xfer));

   assert_ok_after_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ok_o) |-> $past(xfer && kind == FT_TAIL));

   assert_consume_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
      data_ok_o && consume_i |=> !data_ok_o);
endmodule

// File: rtl/flit_unpacker.sv
module flit_unpacker
   import unpk_pkg::*;
#(
   parameter int FLIT_DATA_W = 16,
   parameter int WORD_W      = 32,
   parameter int NUM_SRC     = 4,
   parameter bit MSB_FIRST   = 1'b1,
   localparam int FLIT_W     = FLIT_DATA_W + 2,
   localparam int SRC_W      = $clog2(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flit_val_i,
   input  logic [FLIT_W-1:0] flit_i,
   output logic              flit_ack_o,
   output logic [WORD_W-1:0] word_o,
   output logic [SRC_W-1:0]  src_o,
   output logic              data_ok_o,
   input  logic              consume_i,
   output logic              err_o
);
   localparam int FLITS_PER_WORD = WORD_W / FLIT_DATA_W;

   initial begin
      if (WORD_W % FLIT_DATA_W != 0)
         $fatal(1, "WORD_W must be a multiple of FLIT_DATA_W");
      if (NUM_SRC < 2)
         $fatal(1, "NUM_SRC must be at least 2");
      if (SRC_W > FLIT_DATA_W)
         $fatal(1, "source index wider than a flit");
   end

   flit_kind_e             kind;
   logic [FLIT_DATA_W-1:0] fdata;
   logic                   xfer, shift_en, src_load;
   logic [SRC_W-1:0]       src_q;

   assign kind  = flit_kind_e'(flit_i[FLIT_W-1 -: 2]);
   assign fdata = flit_i[FLIT_DATA_W-1:0];
   assign flit_ack_o = ~data_ok_o;
   assign xfer  = flit_val_i & flit_ack_o;

   unpk_ctrl #(.FLITS_PER_WORD(FLITS_PER_WORD)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer      (xfer),
      .kind      (kind),
      .consume_i (consume_i),
      .shift_en  (shift_en),
      .src_load  (src_load),
      .data_ok_o (data_ok_o),
      .err_o     (err_o)
   );

   unpk_word_shift #(
      .FLIT_DATA_W (FLIT_DATA_W),
      .WORD_W      (WORD_W),
      .MSB_FIRST   (MSB_FIRST)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (fdata),
      .word_o   (word_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        src_q <= '0;
      else if (src_load) src_q <= fdata[SRC_W-1:0];
   end
   assign src_o = src_q;

   assert_word_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      data_ok_o && !consume_i |=> data_ok_o && $stable(word_o) && $stable(src_o));

   assert_no_ok_with_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !data_ok_o);
endmodule

// File: tb/flit_unpacker_tb.sv
module flit_unpacker_tb;
   localparam int FD   = 16;
   localparam int WW   = 32;
   localparam int NSRC = 4;
   localparam int FPW  = WW / FD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flit_val_i = 1'b0;
   logic [FD+1:0] flit_i = '0;
   logic          consume_i = 1'b0;
   logic          flit_ack_o, data_ok_o, err_o;
   logic [WW-1:0] word_o;
   logic [1:0]    src_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   flit_unpacker #(.FLIT_DATA_W(FD), .WORD_W(WW), .NUM_SRC(NSRC)) u_dut (
      .clk(clk), .rst_n(rst_n), .flit_val_i(flit_val_i), .flit_i(flit_i),
      .flit_ack_o(flit_ack_o), .word_o(word_o), .src_o(src_o),
      .data_ok_o(data_ok_o), .consume_i(consume_i), .err_o(err_o));

   // behavioural reference: phase 0 idle, 1 source due, 2 payload, 3 holding
   int            m_phase = 0;
   int            m_cnt = 0;
   logic [WW-1:0] m_acc = '0;
   logic [WW-1:0] m_word = '0;
   int            m_src = 0;
   logic          m_err = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_err = 1'b0;
      end else begin
         m_err = 1'b0;
         if (m_phase == 3) begin
            if (consume_i) m_phase = 0;
         end else if (flit_val_i) begin
            case (m_phase)
               0: if (flit_i[17:16] == 2'b10) m_phase = 1; else m_err = 1'b1;
               1: if (flit_i[17:16] == 2'b00) begin
                     m_src = int'(flit_i[15:0]) % NSRC; m_phase = 2; m_cnt = 0; m_acc = '0;
                  end else begin m_err = 1'b1; m_phase = 0; end
               default: begin
                  if (flit_i[17:16] == 2'b00 && m_cnt < FPW - 1) begin
                     m_acc = (m_acc << FD) | WW'(flit_i[15:0]); m_cnt++;
                  end else if (flit_i[17:16] == 2'b01 && m_cnt == FPW - 1) begin
                     m_acc = (m_acc << FD) | WW'(flit_i[15:0]);
                     m_word = m_acc; m_phase = 3;
                  end else begin m_err = 1'b1; m_phase = 0; end
               end
            endcase
         end
      end
   end

   task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R2/R5 ack", WW'(flit_ack_o), WW'(m_phase != 3));
         check("R5/R6 data_ok", WW'(data_ok_o), WW'(m_phase == 3));
         check("R7 err", WW'(err_o), WW'(m_err));
         if (m_phase == 3) begin
            check("R4 word", word_o, m_word);
            check("R3 src", WW'(src_o), WW'(m_src));
         end
      end
   end

   task automatic send(input logic [1:0] k, input logic [FD-1:0] d);
      flit_i = {k, d};
      flit_val_i = 1'b1;
      while (!flit_ack_o) @(negedge clk);
      @(negedge clk);
      flit_val_i = 1'b0;
   endtask

   task automatic consume();
      consume_i = 1'b1;
      @(negedge clk);
      consume_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 ack", WW'(flit_ack_o), 1);
      check("R1 data_ok", WW'(data_ok_o), 0);
      check("R1 err", WW'(err_o), 0);

      // R2 R3 R4 R5 basic packet
      send(2'b10, 16'hFFFF); send(2'b00, 16'hABC3);
      send(2'b00, 16'h1234); send(2'b01, 16'h5678);
      check("R5 data_ok after trailer", WW'(data_ok_o), 1);
      check("R4 word order", word_o, 32'h1234_5678);
      check("R3 source index", WW'(src_o), 3);
      repeat (2) @(negedge clk);
      check("R5 word held", word_o, 32'h1234_5678);
      consume();
      check("R6 released", WW'(flit_ack_o & ~data_ok_o), 1);

      // R6 consume when idle does nothing
      consume();
      check("R6 idle consume ignored", WW'({flit_ack_o, data_ok_o, err_o}), 3'b100);

      // R2 gaps between flits, val absent
      send(2'b10, 16'h0000); repeat (2) @(negedge clk);
      send(2'b00, 16'h0005); @(negedge clk);
      send(2'b00, 16'hDEAD); repeat (3) @(negedge clk);
      send(2'b01, 16'hBEEF);
      check("R4 word with gaps", word_o, 32'hDEAD_BEEF);
      check("R3 source low bits", WW'(src_o), 1);

      // R8 flit offered while holding is stalled
      fork
         send(2'b10, 16'h1111);
         begin repeat (3) @(negedge clk);
            check("R8 held word unchanged", word_o, 32'hDEAD_BEEF);
            consume(); end
      join
      send(2'b00, 16'h0002); send(2'b00, 16'hCAFE); send(2'b01, 16'hF00D);
      check("R8 stalled header later taken", word_o, 32'hCAFE_F00D);
      check("R3 src after stall", WW'(src_o), 2);
      consume();

      // R7 protocol errors
      send(2'b00, 16'h0001);                              // middle while idle
      send(2'b10, 16'h0); send(2'b10, 16'h0);              // header as source flit
      send(2'b10, 16'h0); send(2'b00, 16'h0); send(2'b01, 16'h7);  // early trailer
      check("R7 no word after early trailer", WW'(data_ok_o), 0);
      send(2'b10, 16'h0); send(2'b00, 16'h0); send(2'b00, 16'h1); send(2'b00, 16'h2); // extra middle
      send(2'b10, 16'h0); send(2'b00, 16'h0); send(2'b11, 16'h3);  // invalid code
      send(2'b10, 16'h0); send(2'b00, 16'h0); send(2'b10, 16'h3);  // header in payload
      check("R7 back in idle", WW'({flit_ack_o, data_ok_o}), 2'b10);

      // recovery and back-to-back packets
      send(2'b10, 16'h0); send(2'b00, 16'h0003);
      send(2'b00, 16'h0102); send(2'b01, 16'h0304);
      check("R7 recovery word", word_o, 32'h0102_0304);
      consume_i = 1'b1; flit_i = {2'b10, 16'h0}; flit_val_i = 1'b1;
      @(negedge clk); consume_i = 1'b0;
      @(negedge clk); flit_val_i = 1'b0;
      send(2'b00, 16'h0000); send(2'b00, 16'hAAAA); send(2'b01, 16'h5555);
      check("R4 back-to-back word", word_o, 32'hAAAA_5555);
      check("R3 back-to-back src", WW'(src_o), 0);
      consume();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule